// File: doc/BRIEF.md
# SPI Flash Command Engine

A small register-mapped engine that runs a single serial-flash transaction each time software asks for one. A transaction is an opcode byte, then zero to eight outgoing bytes, then zero to eight incoming bytes. Chip-select stays low for the whole transaction, and the serial clock runs in mode 0.

Software sets up a transaction in four steps. It writes the opcode and a packed byte-count register. It clears the FIFO pointer and pushes the outgoing bytes through a one-byte data port. Then it sets the go bit and polls until the busy flag drops.

The opcode never passes through the FIFO. Incoming bytes are written into the same eight-entry FIFO, directly after the outgoing ones. To collect them, software clears the pointer again, reads and discards as many entries as it sent, and then reads the replies. The pointer can be read at any time.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every register reads 0x00, `spi_cs_n` is high and `spi_sclk` is low.
- R2: Offset 0x0 holds the opcode and reads back as written. The opcode is always the first byte shifted out, MSB first.
- R3: Offset 0x1 holds the receive count in bits [7:4] and the transmit count in bits [3:0]. A count field above 8 behaves as 8.
- R4: Writing 1 to bit 0 of offset 0x2 starts a transaction. Bit 0 reads 1 while it runs and returns to 0 on its own when the transaction completes.
- R5: Writing 1 to bit 4 of offset 0x2 returns the FIFO pointer to 0. That bit always reads 0.
- R6: Offset 0xC is the FIFO data port. Every write stores a byte at the pointer, and every read returns the byte at the pointer. Both advance the 3-bit pointer modulo 8. Offset 0xD bits [2:0] read the pointer.
- R7: After the opcode, the engine sends FIFO entries 0 through tx-1. While it receives, MOSI is held low. The frame carries exactly 8*(1+tx+rx) clock pulses.
- R8: Received byte j is stored at FIFO entry (tx+j) mod 8. When tx+rx exceeds 8, earlier entries are overwritten and no error is flagged.
- R9: The serial clock idles low and has a period of CLK_DIV system clocks, high for CLK_DIV/2 of them. MOSI changes only while the clock is low, and MISO is sampled on the rising edge.
- R10: Chip-select falls CLK_DIV + CLK_DIV/2 system clocks before the first rising edge. It rises CLK_DIV system clocks after the last falling edge.
- R11: While busy, writes to offsets 0x0 and 0x1, to the go bit, and to the data port have no effect.
- R12: Read data is registered and is valid in the cycle after the read strobe. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip-select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench sweeps every transmit/receive count pair from 0/0 to 8/8. A model slave on the serial pins captures MOSI and returns reply bytes that depend on the opcode and the byte index.

Pairs with tx+rx at or below 8 show that replies land right after the sent bytes. Pairs above 8 exercise the wrap-around overwrite, checked against a mirror of the FIFO kept in the bench. The zero-count cases separate the opcode-only frame and the no-receive frame from the general case.

One extra transaction with count fields of 15 and 12 confirms the clamp to 8. Writes made while busy are checked afterwards through register and pointer readback.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam logic [3:0] OFS_OPCODE = 4'h0;
  localparam logic [3:0] OFS_COUNT  = 4'h1;
  localparam logic [3:0] OFS_CTRL   = 4'h2;
  localparam logic [3:0] OFS_DATA   = 4'hC;
  localparam logic [3:0] OFS_PTR    = 4'hD;
  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_PRST_BIT = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_BITS, ST_TRAIL} eng_state_t;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_clr,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata,
  output logic [PW-1:0] ptr,
  input  logic          eng_we,
  input  logic [PW-1:0] eng_waddr,
  input  logic [W-1:0]  eng_wdata,
  input  logic [PW-1:0] eng_raddr,
  output logic [W-1:0]  eng_rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (eng_we) begin
      mem[eng_waddr] <= eng_wdata;
    end else if (host_we) begin
      mem[ptr] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     ptr <= '0;
    else if (ptr_clr)            ptr <= '0;
    else if (host_we || host_re) ptr <= ptr + PW'(1);
  end

  assign host_rdata = mem[ptr];
  assign eng_rdata  = mem[eng_raddr];

  // R5: a pointer clear lands on entry 0
  p_ptr_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ptr_clr |=> (ptr == '0));
  // R11: the engine and the host never write in the same cycle
  p_single_writer_r11: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> !host_we);
endmodule

// File: rtl/spi_shift_seq.sv
module spi_shift_seq
  import spi_eng_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int MAX_CNT = 8,
  parameter int CNT_W   = 4,
  parameter int PW      = 3,
  localparam int HALF   = DIV / 2,
  localparam int DW     = (DIV > 2) ? $clog2(DIV) : 1,
  localparam int BCW    = $clog2(2 * MAX_CNT + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [7:0]    fifo_rdata,
  output logic [PW-1:0] fifo_raddr,
  output logic          fifo_we,
  output logic [PW-1:0] fifo_waddr,
  output logic [7:0]    fifo_wdata,
  output logic          busy,
  output logic          sclk,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  eng_state_t state;
  logic [DW-1:0]  div_cnt;
  logic [2:0]     bit_cnt;
  logic [BCW-1:0] byte_cnt;
  logic [6:0]     sh;
  logic [7:0]     rx_sh;
  logic           sclk_q, cs_q, mosi_q;
  logic [BCW-1:0] tx_eff, rx_eff, last_byte;
  logic [7:0]     nxt_byte;
  logic           div_last, rise_pt, byte_end;

  assign tx_eff    = (tx_cnt > CNT_W'(MAX_CNT)) ? BCW'(MAX_CNT) : BCW'(tx_cnt);
  assign rx_eff    = (rx_cnt > CNT_W'(MAX_CNT)) ? BCW'(MAX_CNT) : BCW'(rx_cnt);
  assign last_byte = tx_eff + rx_eff;
  assign div_last  = (div_cnt == DW'(DIV - 1));
  assign rise_pt   = (div_cnt == DW'(HALF - 1));
  assign byte_end  = (state == ST_BITS) && div_last && (bit_cnt == 3'd7);

  // next outgoing byte index is byte_cnt+1, which lives in entry byte_cnt
  assign fifo_raddr = byte_cnt[PW-1:0];
  assign nxt_byte   = (byte_cnt < tx_eff) ? fifo_rdata : 8'h00;
  // current byte (index byte_cnt) is a reply when past the sent bytes
  assign fifo_we    = byte_end && (byte_cnt > tx_eff);
  assign fifo_waddr = PW'(byte_cnt - BCW'(1));
  assign fifo_wdata = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; div_cnt <= '0; bit_cnt <= '0; byte_cnt <= '0;
      sh <= '0; rx_sh <= '0; sclk_q <= 1'b0; cs_q <= 1'b1; mosi_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_LEAD; cs_q <= 1'b0; div_cnt <= '0;
        end
        ST_LEAD: if (div_last) begin
          state <= ST_BITS; div_cnt <= '0; bit_cnt <= '0; byte_cnt <= '0;
          sh <= opcode[6:0]; mosi_q <= opcode[7];
        end else div_cnt <= div_cnt + DW'(1);
        ST_BITS: begin
          if (rise_pt) begin
            sclk_q <= 1'b1;
            rx_sh  <= {rx_sh[6:0], miso};
          end
          if (div_last) begin
            sclk_q  <= 1'b0;
            div_cnt <= '0;
            if (bit_cnt == 3'd7) begin
              bit_cnt <= '0;
              if (byte_cnt == last_byte) begin
                state <= ST_TRAIL; mosi_q <= 1'b0;
              end else begin
                byte_cnt <= byte_cnt + BCW'(1);
                sh <= nxt_byte[6:0]; mosi_q <= nxt_byte[7];
              end
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              mosi_q  <= sh[6];
              sh      <= {sh[5:0], 1'b0};
            end
          end else div_cnt <= div_cnt + DW'(1);
        end
        ST_TRAIL: if (div_last) begin
          state <= ST_IDLE; cs_q <= 1'b1; div_cnt <= '0;
        end else div_cnt <= div_cnt + DW'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign mosi = mosi_q;

  // R10: clock pulses only inside a selected frame
  p_sclk_in_frame_r10: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> !cs_q);
  // R9: data out is held while the clock is high
  p_mosi_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_q));
  // R4: an accepted start raises busy
  p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R8: reply bytes are stored only during a live frame
  p_rx_write_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> (busy && !cs_q));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int MAX_BYTES  = 8,
  localparam int PTR_W     = $clog2(FIFO_DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sclk,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [7:0] opcode_q, count_q, rdata_q;
  logic       busy, go, ptr_clr, host_we, host_re, mapped;
  logic [7:0] host_rdata, eng_rdata, eng_wdata;
  logic [PTR_W-1:0] ptr, eng_raddr, eng_waddr;
  logic       eng_we;

  assign go      = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_GO_BIT] && !busy;
  assign ptr_clr = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_PRST_BIT];
  assign host_we = reg_wr && (reg_addr == OFS_DATA) && !busy;
  assign host_re = reg_rd && (reg_addr == OFS_DATA);
  assign mapped  = (reg_addr == OFS_OPCODE) || (reg_addr == OFS_COUNT) ||
                   (reg_addr == OFS_CTRL) || (reg_addr == OFS_DATA) ||
                   (reg_addr == OFS_PTR);

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode_q <= '0;
      count_q  <= '0;
    end else if (reg_wr && !busy) begin
      if (reg_addr == OFS_OPCODE) opcode_q <= reg_wdata;
      if (reg_addr == OFS_COUNT)  count_q  <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        OFS_OPCODE: rdata_q <= opcode_q;
        OFS_COUNT:  rdata_q <= count_q;
        OFS_CTRL:   rdata_q <= {7'b0, busy};
        OFS_DATA:   rdata_q <= host_rdata;
        OFS_PTR:    rdata_q <= 8'(ptr);
        default:    rdata_q <= 8'h00;
      endcase
    end
  end
  assign reg_rdata = rdata_q;

  spi_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) fifo_i (
    .clk, .rst, .ptr_clr, .host_we, .host_re,
    .host_wdata(reg_wdata), .host_rdata, .ptr,
    .eng_we, .eng_waddr, .eng_wdata, .eng_raddr, .eng_rdata
  );

  spi_shift_seq #(.DIV(CLK_DIV), .MAX_CNT(MAX_BYTES), .CNT_W(4), .PW(PTR_W)) seq_i (
    .clk, .rst, .start(go), .opcode(opcode_q),
    .tx_cnt(count_q[3:0]), .rx_cnt(count_q[7:4]),
    .fifo_rdata(eng_rdata), .fifo_raddr(eng_raddr),
    .fifo_we(eng_we), .fifo_waddr(eng_waddr), .fifo_wdata(eng_wdata),
    .busy, .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

  // R11: setup registers cannot move under a running frame
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(opcode_q) && $stable(count_q)));
  // R12: unmapped offsets read zero
  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !mapped) |=> (reg_rdata == 8'h00));
endmodule

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(DIV), .FIFO_DEPTH(8), .MAX_BYTES(8)) dut_i (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso
  );

  // slave model state (written only by the monitor)
  int cur_txe = 0, cur_rxe = 0;
  logic [7:0] cur_op = '0;
  logic [7:0] cap [20];
  int rise_cnt = 0, fall_cnt = 0, lead = 0, trail = 0, bad_high = 0, hi = 0, frames = 0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1;

  function automatic logic [7:0] resp(int j, logic [7:0] op);
    return op ^ (8'h5A + 8'(j * 29));
  endfunction

  function automatic logic slave_bit(int fc, int txe, int rxe, logic [7:0] op);
    int b = fc / 8;
    logic [7:0] v;
    if (b >= 1 + txe && b < 1 + txe + rxe) begin
      v = resp(b - 1 - txe, op);
      return v[7 - (fc % 8)];
    end
    return 1'b0;
  endfunction

  assign spi_miso = slave_bit(fall_cnt, cur_txe, cur_rxe, cur_op);

  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) begin
      rise_cnt = 0; fall_cnt = 0; lead = 0; trail = 0; bad_high = 0; hi = 0;
      frames++;
      for (int i = 0; i < 20; i++) cap[i] = 8'h00;
    end
    if (!spi_cs_n) begin
      if (spi_sclk && !prev_sclk) begin
        if (rise_cnt / 8 < 20) cap[rise_cnt / 8] = {cap[rise_cnt / 8][6:0], spi_mosi};
        rise_cnt++;
      end
      if (!spi_sclk && prev_sclk) begin
        fall_cnt++;
        if (hi != HALF) bad_high++;
      end
      hi = spi_sclk ? hi + 1 : 0;
      if (!spi_sclk && rise_cnt == 0) lead++;
      if (spi_sclk) trail = 0;
      else if (rise_cnt > 0) trail++;
    end
    prev_sclk = spi_sclk;
    prev_cs   = spi_cs_n;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  logic [7:0] mirror [8];

  task automatic run(input logic [7:0] op, input int txf, input int rxf);
    logic [7:0] v;
    int txe, rxe, f0;
    txe = (txf > 8) ? 8 : txf;
    rxe = (rxf > 8) ? 8 : rxf;
    cur_txe = txe; cur_rxe = rxe; cur_op = op;
    wr(4'h0, op);
    wr(4'h1, {4'(rxf), 4'(txf)});
    wr(4'h2, 8'h10);
    for (int k = 0; k < txe; k++) begin
      wr(4'hC, 8'(op + k * 17 + 3));
      mirror[k] = 8'(op + k * 17 + 3);
    end
    rd(4'hD, v); check("R6", v, 32'(txe % 8), "pointer after pushes");
    f0 = frames;
    wr(4'h2, 8'h01);
    rd(4'h2, v); check("R4", v, 32'h01, "busy during frame");
    wr(4'h0, ~op); wr(4'h1, 8'h00); wr(4'hC, 8'hEE); wr(4'h2, 8'h01);
    for (int i = 0; i < 3000; i++) begin
      rd(4'h2, v);
      if (v[0] == 1'b0) break;
    end
    check("R4", v, 32'h00, "busy cleared, go bit low");
    check("R7", rise_cnt, 32'(8 * (1 + txe + rxe)), "clock pulses in frame");
    check("R2", cap[0], op, "opcode first on MOSI");
    for (int k = 0; k < txe; k++)
      check("R7", cap[1 + k], 8'(op + k * 17 + 3), "sent FIFO byte");
    for (int j = 0; j < rxe; j++)
      check("R7", cap[1 + txe + j], 8'h00, "MOSI low while receiving");
    check("R10", lead, DIV + HALF, "select lead time");
    check("R10", trail, DIV, "select trail time");
    check("R9", bad_high, 0, "clock high phases of wrong width");
    rd(4'h0, v); check("R11", v, op, "opcode kept while busy");
    rd(4'h1, v); check("R11", v, {4'(rxf), 4'(txf)}, "counts kept while busy");
    rd(4'hD, v); check("R11", v, 32'(txe % 8), "busy data-port write dropped");
    for (int j = 0; j < rxe; j++) mirror[(txe + j) % 8] = resp(j, op);
    wr(4'h2, 8'h10);
    rd(4'hD, v); check("R5", v, 32'h00, "pointer cleared");
    for (int e = 0; e < 8; e++) begin
      rd(4'hC, v); check("R8", v, mirror[e], $sformatf("FIFO entry %0d", e));
    end
    rd(4'hD, v); check("R6", v, 32'h00, "pointer wrapped after 8 reads");
    repeat (12) @(negedge clk);
    check("R11", frames, f0 + 1, "start while busy ignored");
  endtask

  initial begin
    logic [7:0] v;
    for (int e = 0; e < 8; e++) mirror[e] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1", spi_cs_n, 1, "select idle");
    check("R1", spi_sclk, 0, "clock idle");
    rd(4'h0, v); check("R1", v, 0, "opcode reset");
    rd(4'h1, v); check("R1", v, 0, "counts reset");
    rd(4'h2, v); check("R1", v, 0, "control reset");
    rd(4'hD, v); check("R1", v, 0, "pointer reset");
    wr(4'h0, 8'hA5);
    rd(4'h5, v); check("R12", v, 0, "unmapped offset");
    rd(4'h0, v); check("R12", v, 8'hA5, "registered readback");
    for (int t = 0; t <= 8; t++)
      for (int r = 0; r <= 8; r++)
        run(8'(8'h31 + t * 16 + r), t, r);
    run(8'hC3, 15, 12); // R3 clamp of oversize fields
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule